// File: doc/BRIEF.md
# Extended-Superframe CRC-6 Checker

This block checks the six-bit cyclic redundancy code carried by a DS1 extended superframe. It receives the line as a serial stream, one bit per clock when `bit_valid` is high. An upstream alignment stage supplies two markers. `mf_start` flags the first bit of every multiframe. `fe_flag` flags the bits that hold the framing pattern. The block counts its own position inside the 24-frame, 4632-bit multiframe. It divides the multiframe by the generator polynomial and keeps the remainder until the next multiframe has delivered its six check bits.

When a multiframe ends, the block compares the check bits received in that multiframe with the remainder of the multiframe before it. It gives a one-cycle verdict, with an error pulse on a mismatch, and a saturating counter records the mismatches.

One select input chooses between two sets of calculation rules, and the choice is latched at each multiframe start. In T1 rules a framing-pattern bit enters the division as a one whatever was received. In J1 rules every bit enters the division as received. A resynchronisation pulse, raised whenever the framing format is changed, throws away all partial state.

Top module: `esf_crc6_checker`

## Requirements
- R1: The remainder of a multiframe is M(x)·x^6 mod (x^6 + x + 1). M(x) holds the 4632 bits in arrival order, with the first bit as the highest-degree coefficient, and the division starts from an all-zero register at each multiframe start.
- R2: With T1 rules (`j1_sel` latched as 0), a bit accepted with `fe_flag` high enters the division as a one, whatever its value on `bit_in`.
- R3: With J1 rules (`j1_sel` latched as 1), every accepted bit enters the division with its received value, framing-pattern bits included.
- R4: `j1_sel` is sampled only together with an accepted `mf_start` bit, and that value governs the whole multiframe. Reset selects T1 rules.
- R5: A multiframe is 24 frames of 193 bits, counted from the bit that carries `mf_start`. Its check bits are bit 0 of frames 2, 6, 10, 14, 18 and 22, numbering frames from 1. The check bit in frame 2 is compared with remainder bit 5, the most significant bit, and the check bit in frame 22 with remainder bit 0.
- R6: In the cycle after the last bit of a multiframe is accepted, `check_valid` is high for exactly one cycle. If the check bits of that multiframe differ from the remainder of the previous complete multiframe, `crc_error` is high in that same cycle. `crc_error` is never high without `check_valid`.
- R7: The first complete multiframe after reset, resynchronisation or realignment raises neither `check_valid` nor `crc_error`.
- R8: `err_count` is cleared by reset only. It rises by one with each `crc_error` pulse and stays at its all-ones value (65535 with the default width) once it gets there.
- R9: A cycle with `resync` high discards the partial remainder, the stored previous remainder and the position. Nothing is accepted until the next `mf_start`.
- R10: A cycle with `bit_valid` low has no effect. Bits that arrive after a multiframe is complete and before the next `mf_start` are ignored.
- R11: An `mf_start` that arrives before the current multiframe is complete restarts counting from that bit and discards the stored previous remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| j1_sel | input | 1 | Rule select for the next multiframe: 0 = T1, 1 = J1 |
| resync | input | 1 | Discards all checking state for one cycle (format change) |
| bit_valid | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| mf_start | input | 1 | This bit is the first bit of a multiframe |
| fe_flag | input | 1 | This bit is a framing-pattern bit |
| check_valid | output | 1 | One-cycle pulse when a comparison is made |
| crc_error | output | 1 | One-cycle pulse on a mismatching comparison |
| err_count | output | CNT_W | Saturating count of mismatches |

## Verification
On every cycle, the assertions check several invariants:
- The position counters stay inside the frame geometry and rest at zero while the block is idle.
- Resynchronisation stops acceptance.
- The latched rule select changes only at a multiframe start.
- Verdicts are single-cycle pulses that follow a completed multiframe, and are never given without a stored previous remainder.
- An error pulse never appears without a verdict.
- The counter only ever steps by one on an error, and holds once saturated.

Whether a remainder is numerically right can only be shown by the bench's scenarios. The same holds for the different treatment of framing bits under T1 and J1 rules, for a rule change taking effect only at the next boundary, and for the skipped first comparison after resync or realignment. The bench compares all of this against an independent long-division model.

// File: rtl/esf_crc6_pkg.sv
package esf_crc6_pkg;

  // CRC width and the width of a check-bit slot index
  localparam int CRC_W  = 6;
  localparam int CHK_IW = $clog2(CRC_W);

  typedef logic [CRC_W-1:0] crc_t;

  // x^6 + x + 1: the x^6 term is implicit, the low terms are listed here
  localparam crc_t CRC_LOW_TERMS = 6'b000011;

  // One serial division step, highest-degree coefficient first
  function automatic crc_t crc_step(input crc_t state, input logic din);
    logic fb;
    fb = state[CRC_W-1] ^ din;
    return {state[CRC_W-2:0], 1'b0} ^ (fb ? CRC_LOW_TERMS : '0);
  endfunction

endpackage

// File: rtl/esf_mf_tracker.sv
module esf_mf_tracker
  import esf_crc6_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 24,
  parameter int CHK_STRIDE = 4,
  parameter int CHK_OFFSET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resync,
  input  logic              bit_valid,
  input  logic              mf_start,
  output logic              acc,
  output logic              start,
  output logic              realign,
  output logic              last,
  output logic              chk,
  output logic [CHK_IW-1:0] chk_idx
);

  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(FRAMES);
  localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FRAMES - 1);

  logic          active_q;
  logic [BW-1:0] bcnt_q, cur_b;
  logic [FW-1:0] fcnt_q, cur_f;

  // Position of the bit offered in this cycle
  always_comb begin
    start   = bit_valid & mf_start & ~resync;
    acc     = bit_valid & ~resync & (mf_start | active_q);
    realign = start & active_q;
    cur_b   = start ? '0 : bcnt_q;
    cur_f   = start ? '0 : fcnt_q;
    last    = acc && (cur_f == F_LAST) && (cur_b == B_LAST);
    chk     = acc && (cur_b == '0) && ((int'(cur_f) % CHK_STRIDE) == CHK_OFFSET);
    chk_idx = CHK_IW'(int'(cur_f) / CHK_STRIDE);
  end

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      active_q <= 1'b0;
      bcnt_q   <= '0;
      fcnt_q   <= '0;
    end else if (acc) begin
      if (last) begin
        active_q <= 1'b0;
        bcnt_q   <= '0;
        fcnt_q   <= '0;
      end else begin
        active_q <= 1'b1;
        if (cur_b == B_LAST) begin
          bcnt_q <= '0;
          fcnt_q <= cur_f + 1'b1;
        end else begin
          bcnt_q <= cur_b + 1'b1;
          fcnt_q <= cur_f;
        end
      end
    end
  end

  // R5: position stays inside the frame geometry
  a_r5_pos_range: assert property (@(posedge clk) disable iff (rst)
    (bcnt_q <= B_LAST) && (fcnt_q <= F_LAST));

  // R5: check slots map onto the six remainder bits
  a_r5_chk_slot: assert property (@(posedge clk) disable iff (rst)
    chk |-> (chk_idx < CHK_IW'(CRC_W)));

  // R10: while idle the position rests at zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (bcnt_q == '0) && (fcnt_q == '0));

  // R9: resync leaves the tracker idle
  a_r9_resync_idle: assert property (@(posedge clk) disable iff (rst)
    resync |=> !active_q);

endmodule

// File: rtl/esf_crc6_engine.sv
module esf_crc6_engine
  import esf_crc6_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic resync,
  input  logic acc,
  input  logic start,
  input  logic bit_in,
  input  logic fe_flag,
  input  logic j1_sel,
  output crc_t crc_next
);

  crc_t crc_q;
  logic j1_q;
  logic j1_eff;
  logic din;
  crc_t base;

  always_comb begin
    j1_eff   = start ? j1_sel : j1_q;
    din      = (fe_flag && !j1_eff) ? 1'b1 : bit_in;
    base     = start ? '0 : crc_q;
    crc_next = crc_step(base, din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
      j1_q  <= 1'b0;
    end else if (resync) begin
      crc_q <= '0;
    end else if (acc) begin
      crc_q <= crc_next;
      if (start) j1_q <= j1_sel;
    end
  end

  // R4: rule select changes only with an accepted multiframe start
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(j1_q));

  // R9: resync clears the partial remainder
  a_r9_crc_cleared: assert property (@(posedge clk) disable iff (rst)
    resync |=> (crc_q == '0));

endmodule

// File: rtl/esf_crc_compare.sv
module esf_crc_compare
  import esf_crc6_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resync,
  input  logic              acc,
  input  logic              realign,
  input  logic              last,
  input  logic              chk,
  input  logic [CHK_IW-1:0] chk_idx,
  input  logic              bit_in,
  input  crc_t              crc_next,
  output logic              check_valid,
  output logic              crc_error,
  output logic [CNT_W-1:0]  err_count
);

  crc_t rx_q, rx_now, prev_q;
  logic have_q;

  // Merge the check bit of this cycle; slot 0 lands in the MSB
  for (genvar k = 0; k < CRC_W; k++) begin : g_slot
    localparam logic [CHK_IW-1:0] SLOT = CHK_IW'(CRC_W - 1 - k);
    assign rx_now[k] = (chk && (chk_idx == SLOT)) ? bit_in : rx_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q        <= '0;
      prev_q      <= '0;
      have_q      <= 1'b0;
      check_valid <= 1'b0;
      crc_error   <= 1'b0;
      err_count   <= '0;
    end else begin
      check_valid <= 1'b0;
      crc_error   <= 1'b0;
      if (resync) begin
        have_q <= 1'b0;
      end else if (acc) begin
        rx_q <= rx_now;
        if (realign) have_q <= 1'b0;
        if (last) begin
          prev_q <= crc_next;
          have_q <= 1'b1;
          if (have_q) begin
            check_valid <= 1'b1;
            if (rx_now != prev_q) begin
              crc_error <= 1'b1;
              if (err_count != '1) err_count <= err_count + 1'b1;
            end
          end
        end
      end
    end
  end

  // R6: an error pulse is always part of a verdict
  a_r6_err_in_check: assert property (@(posedge clk) disable iff (rst)
    crc_error |-> check_valid);

  // R6: verdicts last one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    check_valid |=> !check_valid);

  // R7: no verdict without a stored previous remainder
  a_r7_needs_prev: assert property (@(posedge clk) disable iff (rst)
    check_valid |-> $past(have_q));

  // R8: the counter moves only by one, on an error
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (crc_error && (err_count == $past(err_count) + 1'b1)));

  // R8: saturation holds
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (&err_count) |=> (&err_count));

endmodule

// File: rtl/esf_crc6_checker.sv
module esf_crc6_checker
  import esf_crc6_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 24,
  parameter int CHK_STRIDE = 4,
  parameter int CHK_OFFSET = 1,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             j1_sel,
  input  logic             resync,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             mf_start,
  input  logic             fe_flag,
  output logic             check_valid,
  output logic             crc_error,
  output logic [CNT_W-1:0] err_count
);

  logic              acc, start, realign, last, chk;
  logic [CHK_IW-1:0] chk_idx;
  crc_t              crc_next;

  esf_mf_tracker #(
    .FRAME_BITS(FRAME_BITS),
    .FRAMES    (FRAMES),
    .CHK_STRIDE(CHK_STRIDE),
    .CHK_OFFSET(CHK_OFFSET)
  ) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .resync   (resync),
    .bit_valid(bit_valid),
    .mf_start (mf_start),
    .acc      (acc),
    .start    (start),
    .realign  (realign),
    .last     (last),
    .chk      (chk),
    .chk_idx  (chk_idx)
  );

  esf_crc6_engine u_engine (
    .clk     (clk),
    .rst     (rst),
    .resync  (resync),
    .acc     (acc),
    .start   (start),
    .bit_in  (bit_in),
    .fe_flag (fe_flag),
    .j1_sel  (j1_sel),
    .crc_next(crc_next)
  );

  esf_crc_compare #(.CNT_W(CNT_W)) u_compare (
    .clk        (clk),
    .rst        (rst),
    .resync     (resync),
    .acc        (acc),
    .realign    (realign),
    .last       (last),
    .chk        (chk),
    .chk_idx    (chk_idx),
    .bit_in     (bit_in),
    .crc_next   (crc_next),
    .check_valid(check_valid),
    .crc_error  (crc_error),
    .err_count  (err_count)
  );

endmodule

// File: tb/esf_crc6_checker_tb.sv
module esf_crc6_checker_tb;

  localparam int MF_BITS = 4632;
  localparam int FB      = 193;
  localparam int CW      = 3;
  localparam int CMAX    = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic j1_sel = 1'b0, resync = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic mf_start = 1'b0, fe_flag = 1'b0;
  logic check_valid, crc_error;
  logic [CW-1:0] err_count;

  always #10 clk = ~clk;

  esf_crc6_checker #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .j1_sel(j1_sel), .resync(resync),
    .bit_valid(bit_valid), .bit_in(bit_in), .mf_start(mf_start),
    .fe_flag(fe_flag), .check_valid(check_valid), .crc_error(crc_error),
    .err_count(err_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 1'b0;
  int dut_cv_n = 0;
  int dut_er_n = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Long division of M(x)*x^6 by x^6+x+1
  function automatic logic [5:0] div_crc(input bit q[$]);
    logic [6:0] r = '0;
    foreach (q[i]) begin
      r = {r[5:0], q[i]};
      if (r[6]) r = r ^ 7'h43;
    end
    for (int i = 0; i < 6; i++) begin
      r = {r[5:0], 1'b0};
      if (r[6]) r = r ^ 7'h43;
    end
    return r[5:0];
  endfunction

  // ---------------- reference model ----------------
  bit         m_q[$];
  bit         m_active = 0, m_have = 0, m_mode = 0;
  logic [5:0] m_rx = '0, m_prev = '0;
  logic       exp_cv = 0, exp_err = 0;
  int         exp_cnt = 0;
  int         mp, mfr, mbp;

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_have = 0; m_mode = 0;
      exp_cv = 0; exp_err = 0; exp_cnt = 0;
      m_q.delete();
    end else begin
      exp_cv = 0; exp_err = 0;
      if (resync) begin
        m_active = 0; m_have = 0; m_q.delete();
      end else if (bit_valid && (mf_start || m_active)) begin
        if (mf_start) begin
          if (m_active) m_have = 0;
          m_q.delete();
          m_mode = j1_sel;
          m_active = 1;
        end
        mp = m_q.size(); mfr = mp / FB; mbp = mp % FB;
        m_q.push_back((fe_flag && !m_mode) ? 1'b1 : bit_in);
        if (mbp == 0 && (mfr % 4) == 1) m_rx[5 - mfr / 4] = bit_in;
        if (m_q.size() == MF_BITS) begin
          logic [5:0] rem;
          rem = div_crc(m_q);
          if (m_have) begin
            exp_cv = 1;
            exp_err = (m_rx != m_prev);
            if (exp_err && exp_cnt != CMAX) exp_cnt++;
          end
          m_prev = rem; m_have = 1; m_active = 0;
          m_q.delete();
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check("R6 check_valid", int'(check_valid), int'(exp_cv));
      check("R5 crc_error", int'(crc_error), int'(exp_err));
      check("R8 err_count", int'(err_count), exp_cnt);
      if (check_valid) dut_cv_n++;
      if (crc_error) dut_er_n++;
    end
  end

  // ---------------- stimulus ----------------
  logic [5:0] gen_prev = '0;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b0; mf_start = 1'($urandom); bit_in = 1'($urandom); fe_flag = 1'b0;
      @(negedge clk);
    end
  endtask

  // rule_j1: rule used to compute the remainder carried by the next multiframe
  task automatic send_mf(input bit rule_j1, input bit corrupt, input int cut,
                         input int sw_at, input bit sw_val);
    bit mfb[MF_BITS];
    bit fe[MF_BITS];
    bit q[$];
    int n;
    for (int p = 0; p < MF_BITS; p++) begin
      int fr = p / FB;
      fe[p] = 1'b0;
      if (p % FB == 0 && fr % 4 == 3) begin
        fe[p] = 1'b1;
        mfb[p] = (fr == 11) ? 1'b0 : 1'b1;
      end else if (p % FB == 0 && fr % 4 == 1) begin
        mfb[p] = gen_prev[5 - fr / 4] ^ (corrupt && fr == 1);
      end else begin
        mfb[p] = 1'($urandom);
      end
    end
    if (cut == 0) begin
      for (int p = 0; p < MF_BITS; p++) q.push_back((fe[p] && !rule_j1) ? 1'b1 : mfb[p]);
      gen_prev = div_crc(q);
    end
    n = (cut == 0) ? MF_BITS : cut;
    for (int p = 0; p < n; p++) begin
      if (p > 0 && $urandom_range(0, 15) == 0) idle(1);
      bit_valid = 1'b1; bit_in = mfb[p]; mf_start = (p == 0); fe_flag = fe[p];
      if (p == sw_at) j1_sel = sw_val;
      @(negedge clk);
    end
    bit_valid = 1'b0; mf_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset err_count", int'(err_count), 0);
    check("R6 reset check_valid", int'(check_valid), 0);
    check("R6 reset crc_error", int'(crc_error), 0);
    rst = 1'b0;
    started = 1'b1;

    // R1 R2: T1 rules, a zero framing bit treated as one, no errors
    for (int i = 0; i < 4; i++) send_mf(1'b0, 1'b0, 0, -1, 1'b0);
    idle(2);
    check("R1 verdicts after 4 multiframes", dut_cv_n, 3);
    check("R2 T1 good stream errors", int'(err_count), 0);

    // R5: corrupted first check bit; R4: select flips mid multiframe
    send_mf(1'b0, 1'b1, 0, 3000, 1'b1);
    idle(2);
    check("R5 corrupted check bit", dut_er_n, 1);
    check("R7 verdict count", dut_cv_n, 4);

    // R3 R4: J1 rules take over from the next start
    send_mf(1'b1, 1'b0, 0, -1, 1'b0);
    send_mf(1'b1, 1'b0, 0, -1, 1'b0);
    idle(2);
    check("R4 late select change no error", dut_er_n, 1);
    check("R3 J1 good stream", int'(err_count), 1);

    // R2: J1-computed remainder checked with T1 rules must fail
    j1_sel = 1'b0;
    send_mf(1'b1, 1'b0, 0, -1, 1'b0);
    send_mf(1'b0, 1'b0, 0, -1, 1'b0);
    idle(2);
    check("R2 T1 forcing differs from J1", int'(err_count), 2);
    check("R6 verdict count", dut_cv_n, 8);

    // R9 R10 R7: resync mid multiframe, junk without start, then restart
    send_mf(1'b0, 1'b0, 2000, -1, 1'b0);
    resync = 1'b1; @(negedge clk); resync = 1'b0;
    for (int i = 0; i < 300; i++) begin
      bit_valid = 1'b1; bit_in = 1'($urandom); mf_start = 1'b0; fe_flag = 1'($urandom);
      @(negedge clk);
    end
    bit_valid = 1'b0;
    idle(2);
    check("R10 junk ignored", dut_cv_n, 8);
    for (int i = 0; i < 3; i++) send_mf(1'b0, 1'b0, 0, -1, 1'b0);
    idle(2);
    check("R9 R7 first after resync unchecked", dut_cv_n, 10);
    check("R9 errors unchanged", int'(err_count), 2);

    // R11: early start realigns
    send_mf(1'b0, 1'b0, 1000, -1, 1'b0);
    send_mf(1'b0, 1'b0, 0, -1, 1'b0);
    send_mf(1'b0, 1'b0, 0, -1, 1'b0);
    idle(2);
    check("R11 realign skips one verdict", dut_cv_n, 11);
    check("R11 errors unchanged", int'(err_count), 2);

    // R8: saturation
    for (int i = 0; i < 6; i++) send_mf(1'b0, 1'b1, 0, -1, 1'b0);
    idle(2);
    check("R8 error pulses", dut_er_n, 8);
    check("R8 saturated count", int'(err_count), CMAX);
    check("R6 final verdict count", dut_cv_n, 17);

    finish_run();
  end

endmodule